// File: doc/BRIEF.md
# Low-Side Current Limit Chopper

This block keeps the load current of an H-bridge near its limit by cutting the drive whenever the low-side current comparator fires. The comparator arrives already synchronised to the block clock. When it trips, the block raises `limit_active` for a fixed number of clock cycles. The bridge control logic uses that signal to put both legs into high impedance. Once the off-time ends, the bridge is driven again. For a fixed blanking interval after that, the comparator is not looked at, so the current spike from switching cannot cause an immediate new trip.

The limit is not a fault. It does not latch and it does not touch any status flag. Overcurrent above the separate short-circuit threshold goes to a different, latched fault path and does not enter this block. The off-time and blanking length are parameters counted in clock cycles. At the default 200 MHz clock they are about 20.5 µs and 16.5 µs. The longest chop period is then about 37 µs, which allows chopping rates above 20 kHz.

Top module: `ilim_chopper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `limit_active` is 0.
- R2: While `bridge_on` is 0, `ilim_trip` has no effect and `limit_active` stays 0.
- R3: After `bridge_on` rises, the comparator is blanked for BLANK_CYCLES cycles. Counting edges from the first edge that samples `bridge_on` high as edge 0, a trip sampled at edges 0 through BLANK_CYCLES is ignored. This blanking also applies to the first turn-on from idle.
- R4: A trip sampled at edge p, once blanking has ended, sets `limit_active` to 1 after edge p. It stays 1 for exactly OFF_CYCLES cycles and then returns to 0.
- R5: When the off-time ends, the bridge is driven again under a new blanking window of BLANK_CYCLES cycles. If the trip is held high continuously, `limit_active` after edge j equals 1 exactly when (j mod (BLANK_CYCLES+OFF_CYCLES+1)) ≥ BLANK_CYCLES+1.
- R6: A trip that arrives during blanking is discarded. It is not stored, and it causes no later off-time once blanking ends.
- R7: When `bridge_on` drops in any state, `limit_active` is 0 after the next edge and both counters are cleared. The next enable starts a full blanking window.
- R8: The limit is not latched. Once the off-time has elapsed with the trip low, `limit_active` stays 0 with no clearing action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_on | input | 1 | Request for the bridge to be driven |
| ilim_trip | input | 1 | Synchronised low-side current-limit comparator, 1 = at limit |
| limit_active | output | 1 | 1 = force both legs to high impedance for the off-time |

## Verification
The bench sweeps a single-cycle trip across every offset from just after enable to past the end of blanking. The blanking edge matters because a design off by one cycle would either accept a trip on the final blanked edge or miss the first armed one. The sweep also watches long after each early pulse: a design that queued blanked trips would start an off-time once blanking ended. With the trip held high, the output must settle into a fixed period, and a wrong reload of the off counter shows up as a drifting period. Dropping the request in mid-blank and in mid-hold, then re-enabling, exposes a counter that keeps stale counts and so gives a shortened blanking window.

// File: rtl/ilim_chop_pkg.sv
package ilim_chop_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_BLANK = 2'd1,
        CH_ARMED = 2'd2,
        CH_HOLD  = 2'd3
    } chop_state_e;

    typedef struct packed {
        chop_state_e state;
        logic        limit;
    } chop_regs_t;

endpackage

// File: rtl/ilim_span_counter.sv
// Counts while run is high; expire pulses on the last of LIMIT cycles.
// Dropping run clears the count on the next edge.
module ilim_span_counter #(
    parameter int LIMIT = 16,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == W'(LIMIT - 1));
    assign expire = run && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4 / R3: the count never leaves its window
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(LIMIT));

    // R7: an idle counter restarts from zero
    a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/ilim_chopper.sv
module ilim_chopper
    import ilim_chop_pkg::*;
#(
    parameter int OFF_CYCLES   = 4100,
    parameter int BLANK_CYCLES = 3300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bridge_on,
    input  logic ilim_trip,
    output logic limit_active
);

    chop_regs_t r_d, r_q;
    logic       blank_run, blank_done;
    logic       hold_run, hold_done;

    assign blank_run = bridge_on && (r_q.state == CH_BLANK);
    assign hold_run  = bridge_on && (r_q.state == CH_HOLD);

    ilim_span_counter #(.LIMIT(BLANK_CYCLES)) u_blank_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (blank_run),
        .expire (blank_done)
    );

    ilim_span_counter #(.LIMIT(OFF_CYCLES)) u_hold_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (hold_run),
        .expire (hold_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            CH_IDLE:  if (bridge_on)  r_d.state = CH_BLANK;
            CH_BLANK: if (blank_done) r_d.state = CH_ARMED;
            CH_ARMED: if (ilim_trip)  r_d.state = CH_HOLD;
            CH_HOLD:  if (hold_done)  r_d.state = CH_BLANK;
            default:                  r_d.state = CH_IDLE;
        endcase
        if (!bridge_on) begin
            r_d.state = CH_IDLE;
        end
        r_d.limit = (r_d.state == CH_HOLD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: CH_IDLE, limit: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign limit_active = r_q.limit;

    // R2: no request, no limit
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_on |=> !limit_active);

    // R4: an armed trip starts the off-time on the next cycle
    a_r4_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == CH_ARMED && bridge_on && ilim_trip) |=> limit_active);

    // R6: blanking never leads straight into an off-time
    a_r6_blank_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == CH_BLANK) |=> !limit_active);

    // R5: end of an enabled off-time always re-enters blanking
    a_r5_hold_to_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(limit_active) && $past(bridge_on)) |-> r_q.state == CH_BLANK);

endmodule

// File: tb/sim_ilim_chopper.sv
module sim_ilim_chopper;

    localparam int B = 3;
    localparam int O = 5;
    localparam int P = B + O + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bridge_on = 1'b0;
    logic ilim_trip = 1'b0;
    logic limit_active;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ilim_chopper #(.OFF_CYCLES(O), .BLANK_CYCLES(B)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bridge_on    (bridge_on),
        .ilim_trip    (ilim_trip),
        .limit_active (limit_active)
    );

    task automatic check(input string req, input logic exp, input int j);
        n_checks++;
        if (limit_active !== exp) begin
            n_fail++;
            $display("FAIL %s step %0d: limit_active=%b expected %b", req, j, limit_active, exp);
        end
    endtask

    task automatic go_idle(input int n);
        bridge_on = 1'b0;
        ilim_trip = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R7", 1'b0, k);
        end
    endtask

    // trip held high; the request rises so it is sampled at edge 0
    task automatic run_held(input int steps, input string req);
        bridge_on = 1'b1;
        ilim_trip = 1'b1;
        for (int j = 0; j < steps; j++) begin
            @(negedge clk);
            check(req, ((j % P) >= B + 1), j);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 1);

        // R2: trip toggling while the request is low
        for (int k = 0; k < 6; k++) begin
            ilim_trip = k[0];
            @(negedge clk);
            check("R2", 1'b0, k);
        end

        // R3 / R4 / R6 / R8: single-cycle trip at every offset
        for (int p = 1; p <= B + 4; p++) begin
            go_idle(2);
            bridge_on = 1'b1;
            ilim_trip = 1'b0;
            for (int j = 0; j < p + O + B + 6; j++) begin
                @(negedge clk);
                if (p >= B + 1)
                    check((j < p) ? "R3" : "R4_R8", (j >= p && j < p + O), j);
                else
                    check("R6", 1'b0, j);
                ilim_trip = (j + 1 == p);
            end
        end

        // R5: continuous trip, periodic chopping from first enable
        go_idle(2);
        run_held(4 * P, "R5");

        // R7: drop mid-hold, then full pattern from a fresh enable
        go_idle(2);
        run_held(B + 3, "R5");
        go_idle(3);
        run_held(2 * P, "R7");

        // R7: drop mid-blank, then full blanking again
        go_idle(2);
        run_held(2, "R3");
        go_idle(2);
        run_held(2 * P, "R7");

        go_idle(1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule